// File: doc/BRIEF.md
# Readback Security Gate

This block decides, request by request, whether configuration readback may proceed. It keeps a two-bit protection level, which a dedicated security-frame strobe loads, and answers every readback request with exactly one single-cycle pulse: grant or deny. The readback data path is outside the block. It sees only the request and reports only the verdict.

Four protection levels exist. The value 00 permits any number of readbacks. The values 01 and 10 each permit one readback and then lock out later requests. The value 11 forbids readback altogether. Internally the level and the "already used" condition are folded into a four-state machine:

- OPEN: readback is unlimited.
- ARMED: a one-shot readback is still available.
- SPENT: the one-shot readback has been consumed.
- LOCKED: readback is forbidden.

The transitions are:

- load-open: a frame with 00 moves any state to OPEN.
- load-once: a frame with 01 or 10 moves any state to ARMED.
- load-lock: a frame with 11 moves any state to LOCKED.
- consume: a request in ARMED with no frame in the same cycle moves to SPENT.
- reset: moves to OPEN.

Top module: `rb_guard`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, neither `rd_grant` nor `rd_deny` is high without a request, and the level after reset is 00 (open).
- R2: A request sampled at a rising clock edge produces exactly one of `rd_grant`/`rd_deny`, high for one cycle after that edge. A cycle with no request produces neither.
- R3: At level 00 every request is granted.
- R4: After a frame loads level 01, the first request is granted and every later request is denied.
- R5: Level 10 behaves exactly as level 01: one grant, then denials.
- R6: At level 11 every request is denied.
- R7: A new security frame of 01 or 10 re-arms the one-shot permission, even after it was used.
- R8: A request in the same cycle as a security frame is judged by the level in force before that frame. The frame takes effect from the next cycle, and a grant in that cycle does not consume the newly loaded one-shot.
- R9: Reset clears a consumed one-shot and restores level 00, so requests after reset are granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_wr | input | 1 | Security-frame load strobe |
| sec_lvl | input | 2 | Protection level carried by the frame (00 open, 01/10 one-shot, 11 locked) |
| rd_req | input | 1 | Readback request, one per cycle high |
| rd_grant | output | 1 | One-cycle grant, one clock after the request |
| rd_deny | output | 1 | One-cycle deny, one clock after the request |

## Verification
A security-frame load and a readback request can fall in the same cycle. In that cycle the gate must judge the request by the old level while installing the new one. The bench provokes this by issuing both together in several combinations: a lock frame over an open level, an open frame over a locked level, and a one-shot frame over a one-shot level that is still armed. It then checks the verdict for that cycle and the verdict for the request that follows. The scoreboard predicts both from the prior level and from the rule that the frame clears any consumption.

// File: rtl/rbg_pkg.sv
package rbg_pkg;

    localparam int unsigned LVL_W = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_OPEN   = 2'b00;
    localparam lvl_t LVL_ONCE_A = 2'b01;
    localparam lvl_t LVL_ONCE_B = 2'b10;
    localparam lvl_t LVL_NONE   = 2'b11;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SPENT  = 2'd2,
        ST_LOCKED = 2'd3
    } gate_st_e;

endpackage

// File: rtl/rbg_decode.sv
module rbg_decode
    import rbg_pkg::*;
(
    input  lvl_t     level,
    output gate_st_e entry_st
);

    // State entered when a security frame carrying `level` is loaded.
    always_comb begin
        unique case (level)
            LVL_OPEN:   entry_st = ST_OPEN;
            LVL_ONCE_A: entry_st = ST_ARMED;
            LVL_ONCE_B: entry_st = ST_ARMED;
            LVL_NONE:   entry_st = ST_LOCKED;
            default:    entry_st = ST_LOCKED;
        endcase
    end

endmodule

// File: rtl/rbg_fsm.sv
module rbg_fsm
    import rbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  gate_st_e entry_st,
    input  logic     req,
    output gate_st_e state
);

    gate_st_e state_q;
    gate_st_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: a frame load overrides consumption in the same cycle
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = entry_st;
        end else begin
            unique case (state_q)
                ST_OPEN:   state_d = ST_OPEN;
                ST_ARMED:  state_d = req ? ST_SPENT : ST_ARMED;
                ST_SPENT:  state_d = ST_SPENT;
                ST_LOCKED: state_d = ST_LOCKED;
                default:   state_d = ST_LOCKED;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/rbg_resp.sv
module rbg_resp
    import rbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req,
    input  gate_st_e state,
    output logic     grant,
    output logic     deny
);

    logic allow;
    logic grant_q;
    logic deny_q;

    // Permission given by the state in force when the request is sampled
    always_comb begin
        unique case (state)
            ST_OPEN:   allow = 1'b1;
            ST_ARMED:  allow = 1'b1;
            ST_SPENT:  allow = 1'b0;
            ST_LOCKED: allow = 1'b0;
            default:   allow = 1'b0;
        endcase
    end

    // Output process: one verdict pulse per request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= req &  allow;
            deny_q  <= req & ~allow;
        end
    end

    assign grant = grant_q;
    assign deny  = deny_q;

endmodule

// File: rtl/rb_guard.sv
module rb_guard
    import rbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_wr,
    input  logic [LVL_W-1:0] sec_lvl,
    input  logic             rd_req,
    output logic             rd_grant,
    output logic             rd_deny
);

    gate_st_e entry_st;
    gate_st_e cur_st;

    rbg_decode u_decode (
        .level    (sec_lvl),
        .entry_st (entry_st)
    );

    rbg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sec_wr),
        .entry_st (entry_st),
        .req      (rd_req),
        .state    (cur_st)
    );

    rbg_resp u_resp (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rd_req),
        .state (cur_st),
        .grant (rd_grant),
        .deny  (rd_deny)
    );

endmodule

// File: rtl/rb_guard_chk.sv
module rb_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_wr,
    input logic [1:0] sec_lvl,
    input logic       rd_req,
    input logic       rd_grant,
    input logic       rd_deny
);

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_grant && rd_deny)); // R2

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_grant || rd_deny)); // R2

    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_grant && !rd_deny)); // R1

    AST_OPEN_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !sec_wr && $past(sec_wr && sec_lvl == 2'b00)) |=> rd_grant); // R3

    AST_LOCK_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !sec_wr && $past(sec_wr && sec_lvl == 2'b11)) |=> rd_deny); // R6

    AST_ONESHOT_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !sec_wr && $past(rd_req && !sec_wr)
         && $past(sec_wr && sec_lvl == 2'b01, 2)) |=> rd_deny); // R4

    AST_COLLIDE_OLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sec_wr && sec_lvl == 2'b00
         && $past(sec_wr && sec_lvl == 2'b11)) |=> rd_deny); // R8

endmodule

bind rb_guard rb_guard_chk u_chk (.*);

// File: tb/rb_guard_tb.sv
module rb_guard_tb;

    typedef struct {
        bit    g;
        bit    d;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_wr = 1'b0;
    logic [1:0] sec_lvl = 2'b00;
    logic       rd_req = 1'b0;
    logic       rd_grant;
    logic       rd_deny;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // Reference model, built from the requirements
    int m_lvl = 0;
    bit m_used = 1'b0;

    always #4 clk = ~clk;

    rb_guard u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_wr   (sec_wr),
        .sec_lvl  (sec_lvl),
        .rd_req   (rd_req),
        .rd_grant (rd_grant),
        .rd_deny  (rd_deny)
    );

    // Driver: one cycle of stimulus and one expected item
    task automatic step(input bit req, input bit wr, input bit [1:0] lvl, input string tag);
        exp_t e;
        bit   ok;
        @(negedge clk);
        rd_req  = req;
        sec_wr  = wr;
        sec_lvl = lvl;
        ok    = (m_lvl == 0) || ((m_lvl == 1 || m_lvl == 2) && !m_used);
        e.g   = req && ok;
        e.d   = req && !ok;
        e.tag = tag;
        sb.push_back(e);
        if (wr) begin
            m_lvl  = int'(lvl);
            m_used = 1'b0;
        end else if (e.g && (m_lvl == 1 || m_lvl == 2)) begin
            m_used = 1'b1;
        end
    endtask

    task automatic direct_check(input bit cond, input string tag, input string what);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Monitor: pops one expected item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rd_grant !== e.g || rd_deny !== e.d) begin
                    errors++;
                    $display("FAIL %s: grant/deny actual %b%b expected %b%b",
                             e.tag, rd_grant, rd_deny, e.g, e.d);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: quiet during reset
        repeat (3) @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        direct_check(rd_grant === 1'b0 && rd_deny === 1'b0, "R1",
                     $sformatf("in reset actual %b%b expected 00", rd_grant, rd_deny));
        rd_req = 1'b0;
        rst_n  = 1'b1;
        m_lvl  = 0;
        m_used = 1'b0;

        // R1/R3: default level open, idle cycles quiet
        step(1'b0, 1'b0, 2'b00, "R1");
        step(1'b1, 1'b0, 2'b00, "R3");
        step(1'b1, 1'b0, 2'b00, "R3");
        step(1'b0, 1'b0, 2'b00, "R2");
        step(1'b1, 1'b0, 2'b00, "R3");

        // R4: one-shot via 01
        step(1'b0, 1'b1, 2'b01, "R4");
        step(1'b0, 1'b0, 2'b00, "R2");
        step(1'b1, 1'b0, 2'b00, "R4");
        step(1'b1, 1'b0, 2'b00, "R4");
        step(1'b1, 1'b0, 2'b00, "R4");

        // R7: re-arm by a fresh frame, here 10 (R5)
        step(1'b0, 1'b1, 2'b10, "R7");
        step(1'b1, 1'b0, 2'b00, "R5");
        step(1'b0, 1'b0, 2'b00, "R2");
        step(1'b1, 1'b0, 2'b00, "R5");

        // R6: locked
        step(1'b0, 1'b1, 2'b11, "R6");
        step(1'b1, 1'b0, 2'b00, "R6");
        step(1'b1, 1'b0, 2'b00, "R6");

        // R8: collisions of frame and request
        step(1'b1, 1'b1, 2'b00, "R8");   // judged locked -> deny
        step(1'b1, 1'b0, 2'b00, "R8");   // now open -> grant
        step(1'b1, 1'b1, 2'b11, "R8");   // judged open -> grant
        step(1'b1, 1'b0, 2'b00, "R8");   // now locked -> deny
        step(1'b0, 1'b1, 2'b01, "R8");
        step(1'b1, 1'b1, 2'b10, "R8");   // armed: grant, reload keeps it armed
        step(1'b1, 1'b0, 2'b00, "R8");   // still armed -> grant
        step(1'b1, 1'b0, 2'b00, "R8");   // spent -> deny

        // R9: reset clears consumption and restores open
        step(1'b0, 1'b0, 2'b00, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        direct_check(rd_grant === 1'b0 && rd_deny === 1'b0, "R9",
                     $sformatf("after reset actual %b%b expected 00", rd_grant, rd_deny));
        rst_n  = 1'b1;
        m_lvl  = 0;
        m_used = 1'b0;
        step(1'b1, 1'b0, 2'b00, "R9");
        step(1'b1, 1'b0, 2'b00, "R9");
        step(1'b0, 1'b0, 2'b00, "R2");

        repeat (3) @(negedge clk);
        direct_check(sb.size() == 0, "R2",
                     $sformatf("pending items actual %0d expected 0", sb.size()));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule